// File: doc/BRIEF.md
# Branch Target Buffer with Two-Bit Prediction

This block is a small fully associative table of recently resolved branches. The fetch stage presents the address of the instruction it is fetching. When that address matches a stored branch, the buffer flags the instruction as a branch, returns the target recorded for it, and says whether the branch is predicted taken. Fetch can then steer the next address to that target without waiting for the branch to execute. The lookup outputs are combinational from the stored state, so fetch can use them in the same cycle.

When a branch resolves, the execution side reports the branch address, its computed target and its outcome. A branch that is not yet in the table is allocated an entry. If every entry is in use, the least recently used entry is overwritten. A branch that is already present has its two-bit saturating predictor moved one step towards the observed outcome. Recency is tracked exactly over all entries. Both lookup hits and resolutions count as uses of an entry.

Top module: `branch_target_buffer`

## Requirements
- R1: After reset every entry is empty, so every lookup misses until a branch has been resolved.
- R2: With `lk_en` high, a lookup hits when a valid entry holds the address `lk_pc`. On a hit, `lk_target` is that entry's stored target and `lk_taken` is 1 exactly when its prediction code is 0 (strong taken) or 1 (weak taken).
- R3: When `lk_en` is low or no entry matches, `lk_hit` and `lk_taken` are 0 and `lk_target` is all zeros.
- R4: A resolution (`up_valid` high) whose address is not held is written into an entry at the next clock edge, together with its target. Its prediction code starts at 1 (weak taken) if `up_taken` is 1, and at 3 (weak not taken) otherwise.
- R5: A resolution of an address that is already held changes only that entry's prediction code and keeps its stored target. On taken the code goes 2→3, 3→1, 1→0 and 0→0. On not taken it goes 0→1, 1→3, 3→2 and 2→2.
- R6: An insertion uses the lowest-numbered empty entry if one exists, and an address is never held in more than one entry.
- R7: When all entries are full, an insertion replaces the least recently used entry, judged on the order before the current cycle's uses. A lookup hit and a resolution each make their entry the most recently used. When both happen in the same cycle on different entries, the resolved entry ends up more recent.
- R8: When a lookup and a resolution touch the same address in one cycle, the lookup reports the state from before that cycle's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_en | input | 1 | Lookup request qualifier |
| lk_pc | input | PC_W | Address of the instruction being fetched |
| lk_hit | output | 1 | The fetched instruction is a known branch |
| lk_target | output | TGT_W | Stored target on a hit, zero otherwise |
| lk_taken | output | 1 | Hit and predicted taken |
| up_valid | input | 1 | A branch resolution is presented this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_target | input | TGT_W | Computed target of the resolved branch |
| up_taken | input | 1 | Outcome of the resolved branch |

## Verification
The bench builds the block with the default 8 entries and 32-bit address and target widths. It draws branch addresses from a pool of twelve values, larger than the table, so that fills, LRU evictions and re-insertion of evicted branches all occur many times. Directed phases walk one entry through every predictor transition, including both saturating ends. They also fill the table exactly and then force an eviction right after a lookup has refreshed the oldest entry. Finally they collide a lookup and a resolution on one address.

// File: rtl/btb_pkg.sv
package btb_pkg;

   // Two-bit prediction codes; numeric values are fixed by the requirements.
   localparam logic [1:0] PRED_STRONG_T = 2'd0;
   localparam logic [1:0] PRED_WEAK_T   = 2'd1;
   localparam logic [1:0] PRED_STRONG_N = 2'd2;
   localparam logic [1:0] PRED_WEAK_N   = 2'd3;

   // Next predictor code given the current code and the observed outcome.
   function automatic logic [1:0] pred_step(input logic [1:0] cur, input logic taken);
      logic [1:0] nxt;
      case (cur)
         PRED_STRONG_T: nxt = taken ? PRED_STRONG_T : PRED_WEAK_T;
         PRED_WEAK_T:   nxt = taken ? PRED_STRONG_T : PRED_WEAK_N;
         PRED_WEAK_N:   nxt = taken ? PRED_WEAK_T   : PRED_STRONG_N;
         default:       nxt = taken ? PRED_WEAK_N   : PRED_STRONG_N;
      endcase
      return nxt;
   endfunction

   // Starting code for a freshly allocated entry.
   function automatic logic [1:0] pred_seed(input logic taken);
      return taken ? PRED_WEAK_T : PRED_WEAK_N;
   endfunction

   // Codes 0 and 1 both mean "predict taken".
   function automatic logic pred_is_taken(input logic [1:0] cur);
      return (cur == PRED_STRONG_T) || (cur == PRED_WEAK_T);
   endfunction

endpackage

// File: rtl/btb_cam.sv
// Associative compare of one key against every stored address.
module btb_cam #(
   parameter int N_ENTRIES = 8,
   parameter int KEY_W     = 32,
   localparam int IW       = $clog2(N_ENTRIES)
) (
   input  logic [N_ENTRIES-1:0]            valid,
   input  logic [N_ENTRIES-1:0][KEY_W-1:0] keys,
   input  logic [KEY_W-1:0]                key,
   output logic [N_ENTRIES-1:0]            match,
   output logic                            hit,
   output logic [IW-1:0]                   idx
);

   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
      assign match[i] = valid[i] && (keys[i] == key);
   end

   assign hit = |match;

   always_comb begin
      idx = '0;
      for (int i = 0; i < N_ENTRIES; i++) begin
         if (match[i]) idx = IW'(i);
      end
   end

endmodule

// File: rtl/btb_lru.sv
// Exact recency tracking with one age counter per entry (0 = newest).
module btb_lru #(
   parameter int N_ENTRIES = 8,
   localparam int IW       = $clog2(N_ENTRIES)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         first_en,
   input  logic [IW-1:0]                first_idx,
   input  logic                         second_en,
   input  logic [IW-1:0]                second_idx,
   output logic [IW-1:0]                oldest_idx,
   output logic [N_ENTRIES-1:0][IW-1:0] ages
);

   localparam logic [IW-1:0] AGE_MAX = IW'(N_ENTRIES - 1);

   logic [N_ENTRIES-1:0][IW-1:0] age_q;
   logic [N_ENTRIES-1:0][IW-1:0] age_mid;
   logic [N_ENTRIES-1:0][IW-1:0] age_nxt;

   // First touch (lookup hit).
   always_comb begin
      age_mid = age_q;
      if (first_en) begin
         for (int j = 0; j < N_ENTRIES; j++) begin
            if (age_q[j] < age_q[first_idx]) age_mid[j] = age_q[j] + 1'b1;
         end
         age_mid[first_idx] = '0;
      end
   end

   // Second touch (resolution) applied on top, so it ends up newest.
   always_comb begin
      age_nxt = age_mid;
      if (second_en) begin
         for (int j = 0; j < N_ENTRIES; j++) begin
            if (age_mid[j] < age_mid[second_idx]) age_nxt[j] = age_mid[j] + 1'b1;
         end
         age_nxt[second_idx] = '0;
      end
   end

   for (genvar j = 0; j < N_ENTRIES; j++) begin : g_age
      always_ff @(posedge clk) begin
         if (!rst_n) age_q[j] <= IW'(j);
         else        age_q[j] <= age_nxt[j];
      end
   end

   always_comb begin
      oldest_idx = '0;
      for (int j = 0; j < N_ENTRIES; j++) begin
         if (age_q[j] == AGE_MAX) oldest_idx = IW'(j);
      end
   end

   assign ages = age_q;

endmodule

// File: rtl/btb_victim.sv
// Chooses the entry an insertion will overwrite.
module btb_victim #(
   parameter int N_ENTRIES = 8,
   localparam int IW       = $clog2(N_ENTRIES)
) (
   input  logic [N_ENTRIES-1:0] valid,
   input  logic [IW-1:0]        oldest_idx,
   output logic [IW-1:0]        victim_idx
);

   // Lowest free slot wins; scanning downward lets the lowest overwrite.
   always_comb begin
      victim_idx = oldest_idx;
      for (int i = N_ENTRIES - 1; i >= 0; i--) begin
         if (!valid[i]) victim_idx = IW'(i);
      end
   end

endmodule

// File: rtl/branch_target_buffer.sv
module branch_target_buffer
   import btb_pkg::*;
#(
   parameter int N_ENTRIES = 8,
   parameter int PC_W      = 32,
   parameter int TGT_W     = 32,
   localparam int IW       = $clog2(N_ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_en,
   input  logic [PC_W-1:0]  lk_pc,
   output logic             lk_hit,
   output logic [TGT_W-1:0] lk_target,
   output logic             lk_taken,
   input  logic             up_valid,
   input  logic [PC_W-1:0]  up_pc,
   input  logic [TGT_W-1:0] up_target,
   input  logic             up_taken
);

   if (N_ENTRIES < 2) begin : g_bad_depth
      $error("branch_target_buffer: N_ENTRIES must be at least 2");
   end
   if (PC_W < 1 || TGT_W < 1) begin : g_bad_width
      $error("branch_target_buffer: address and target widths must be positive");
   end

   logic [N_ENTRIES-1:0]             valid_q;
   logic [N_ENTRIES-1:0][PC_W-1:0]   pc_q;
   logic [N_ENTRIES-1:0][TGT_W-1:0]  tgt_q;
   logic [N_ENTRIES-1:0][1:0]        pred_q;

   logic [N_ENTRIES-1:0]             lk_match;
   logic                             lk_any;
   logic [IW-1:0]                    lk_idx;
   logic [N_ENTRIES-1:0]             up_match;
   logic                             up_hit;
   logic [IW-1:0]                    up_hit_idx;
   logic [IW-1:0]                    oldest_idx;
   logic [IW-1:0]                    victim_idx;
   logic [IW-1:0]                    wr_idx;
   logic [N_ENTRIES-1:0][IW-1:0]     ages;

   btb_cam #(.N_ENTRIES(N_ENTRIES), .KEY_W(PC_W)) u_cam_lk (
      .valid (valid_q),
      .keys  (pc_q),
      .key   (lk_pc),
      .match (lk_match),
      .hit   (lk_any),
      .idx   (lk_idx)
   );

   btb_cam #(.N_ENTRIES(N_ENTRIES), .KEY_W(PC_W)) u_cam_up (
      .valid (valid_q),
      .keys  (pc_q),
      .key   (up_pc),
      .match (up_match),
      .hit   (up_hit),
      .idx   (up_hit_idx)
   );

   btb_victim #(.N_ENTRIES(N_ENTRIES)) u_victim (
      .valid      (valid_q),
      .oldest_idx (oldest_idx),
      .victim_idx (victim_idx)
   );

   assign wr_idx = up_hit ? up_hit_idx : victim_idx;

   btb_lru #(.N_ENTRIES(N_ENTRIES)) u_lru (
      .clk        (clk),
      .rst_n      (rst_n),
      .first_en   (lk_hit),
      .first_idx  (lk_idx),
      .second_en  (up_valid),
      .second_idx (wr_idx),
      .oldest_idx (oldest_idx),
      .ages       (ages)
   );

   // Lookup path: combinational from the stored state.
   assign lk_hit    = lk_en && lk_any;
   assign lk_target = lk_hit ? tgt_q[lk_idx] : '0;
   assign lk_taken  = lk_hit && pred_is_taken(pred_q[lk_idx]);

   // Per-entry storage and update.
   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_entry
      logic sel;
      assign sel = up_valid && (wr_idx == IW'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q[i] <= 1'b0;
         end else if (sel && !up_hit) begin
            valid_q[i] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            if (up_hit) begin
               pred_q[i] <= pred_step(pred_q[i], up_taken);
            end else begin
               pc_q[i]   <= up_pc;
               tgt_q[i]  <= up_target;
               pred_q[i] <= pred_seed(up_taken);
            end
         end
      end
   end

endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
   parameter int N_ENTRIES = 8,
   parameter int TGT_W     = 32,
   localparam int IW       = $clog2(N_ENTRIES)
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         lk_hit,
   input logic                         lk_taken,
   input logic [TGT_W-1:0]             lk_target,
   input logic                         up_valid,
   input logic                         up_taken,
   input logic                         up_hit,
   input logic [IW-1:0]                wr_idx,
   input logic [N_ENTRIES-1:0]         valid_q,
   input logic [N_ENTRIES-1:0][1:0]    pred_q,
   input logic [N_ENTRIES-1:0]         lk_match,
   input logic [N_ENTRIES-1:0]         up_match,
   input logic [N_ENTRIES-1:0][IW-1:0] ages
);

   logic [N_ENTRIES-1:0] is_oldest;
   logic [1:0]           cur_pred;

   always_comb begin
      for (int j = 0; j < N_ENTRIES; j++) begin
         is_oldest[j] = (ages[j] == IW'(N_ENTRIES - 1));
      end
   end

   assign cur_pred = pred_q[wr_idx];

   assert_quiet_on_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (!lk_taken && lk_target == '0));

   assert_unique_lookup_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match));

   assert_unique_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(up_match));

   assert_fill_grows_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && !up_hit && !(&valid_q)) |=>
         ($countones(valid_q) == $past($countones(valid_q)) + 1));

   assert_seed_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && !up_hit) |=>
         (pred_q[$past(wr_idx)] == ($past(up_taken) ? 2'd1 : 2'd3)));

   assert_weak_t_saturates_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_hit && up_taken && cur_pred == 2'd1) |=>
         (pred_q[$past(wr_idx)] == 2'd0));

   assert_weak_n_saturates_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_hit && !up_taken && cur_pred == 2'd3) |=>
         (pred_q[$past(wr_idx)] == 2'd2));

   assert_single_oldest_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(is_oldest));

endmodule

bind branch_target_buffer btb_checker #(
   .N_ENTRIES (N_ENTRIES),
   .TGT_W     (TGT_W)
) u_btb_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .lk_hit    (lk_hit),
   .lk_taken  (lk_taken),
   .lk_target (lk_target),
   .up_valid  (up_valid),
   .up_taken  (up_taken),
   .up_hit    (up_hit),
   .wr_idx    (wr_idx),
   .valid_q   (valid_q),
   .pred_q    (pred_q),
   .lk_match  (lk_match),
   .up_match  (up_match),
   .ages      (ages)
);

// File: tb/branch_target_buffer_tb.sv
`timescale 1ns/1ps
module branch_target_buffer_tb;

   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_en = 1'b0;
   logic [31:0] lk_pc = '0;
   logic        lk_hit;
   logic [31:0] lk_target;
   logic        lk_taken;
   logic        up_valid = 1'b0;
   logic [31:0] up_pc = '0;
   logic [31:0] up_target = '0;
   logic        up_taken = 1'b0;

   int    n_checks = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   string tag = "R1";

   // Behavioural model state.
   bit          m_val [N];
   logic [31:0] m_pc  [N];
   logic [31:0] m_tgt [N];
   int          m_pred[N];
   int          order[$];   // front = most recent

   always #4 clk = ~clk;   // 125 MHz

   branch_target_buffer u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_en     (lk_en),
      .lk_pc     (lk_pc),
      .lk_hit    (lk_hit),
      .lk_target (lk_target),
      .lk_taken  (lk_taken),
      .up_valid  (up_valid),
      .up_pc     (up_pc),
      .up_target (up_target),
      .up_taken  (up_taken)
   );

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic int find(input logic [31:0] p);
      for (int i = 0; i < N; i++) if (m_val[i] && m_pc[i] == p) return i;
      return -1;
   endfunction

   function automatic void touch(input int e);
      for (int k = 0; k < order.size(); k++) begin
         if (order[k] == e) begin
            order.delete(k);
            break;
         end
      end
      order.push_front(e);
   endfunction

   function automatic int next_code(input int c, input bit tk);
      case (c)
         0: return tk ? 0 : 1;
         1: return tk ? 0 : 3;
         3: return tk ? 1 : 2;
         default: return tk ? 3 : 2;
      endcase
   endfunction

   function automatic void model_reset();
      order.delete();
      for (int i = 0; i < N; i++) begin
         m_val[i] = 1'b0;
         order.push_back(i);
      end
   endfunction

   // One clock: drive, compare outputs against the model, advance the model.
   task automatic step(input bit le, input logic [31:0] lp, input bit uv,
                       input logic [31:0] upc, input logic [31:0] ut, input bit utk);
      int ml, mu, v, wr;
      bit exp_hit;
      @(negedge clk);
      lk_en = le; lk_pc = lp; up_valid = uv; up_pc = upc; up_target = ut; up_taken = utk;
      #1;
      ml = find(lp);
      exp_hit = le && (ml >= 0);
      check("lk_hit", {31'd0, lk_hit}, {31'd0, exp_hit});
      check("lk_target", lk_target, exp_hit ? m_tgt[ml] : 32'd0);
      check("lk_taken", {31'd0, lk_taken}, {31'd0, exp_hit && (m_pred[ml] < 2)});
      if (uv) begin
         mu = find(upc);
         v = -1;
         for (int i = 0; i < N; i++) if (!m_val[i]) begin v = i; break; end
         if (v < 0) v = order[$];
         wr = (mu >= 0) ? mu : v;
         if (mu >= 0) m_pred[mu] = next_code(m_pred[mu], utk);
         else begin
            m_val[v] = 1'b1; m_pc[v] = upc; m_tgt[v] = ut; m_pred[v] = utk ? 1 : 3;
         end
         if (exp_hit) touch(ml);
         touch(wr);
      end else if (exp_hit) begin
         touch(ml);
      end
   endtask

   function automatic logic [31:0] pcv(input int k);
      return 32'h0000_1000 + 32'(k) * 4;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: empty after reset, every lookup misses.
      tag = "R1";
      for (int k = 0; k < 4; k++) step(1, pcv(k), 0, 0, 0, 0);

      // R4: insertion seeds weak taken / weak not taken.
      tag = "R4";
      step(0, 0, 1, pcv(0), 32'hA000_0000, 1);
      step(1, pcv(0), 1, pcv(1), 32'hB000_0000, 0);
      step(1, pcv(1), 0, 0, 0, 0);

      // R5: walk entry pcv(0) through all transitions; target must not change.
      tag = "R5";
      step(1, pcv(0), 1, pcv(0), 32'hDEAD_0000, 0); // 1 -> 3
      step(1, pcv(0), 1, pcv(0), 32'hDEAD_0001, 0); // 3 -> 2
      step(1, pcv(0), 1, pcv(0), 32'hDEAD_0002, 0); // 2 -> 2
      step(1, pcv(0), 1, pcv(0), 32'hDEAD_0003, 1); // 2 -> 3
      step(1, pcv(0), 1, pcv(0), 32'hDEAD_0004, 1); // 3 -> 1
      step(1, pcv(0), 1, pcv(0), 32'hDEAD_0005, 1); // 1 -> 0
      step(1, pcv(0), 1, pcv(0), 32'hDEAD_0006, 1); // 0 -> 0
      step(1, pcv(0), 1, pcv(0), 32'hDEAD_0007, 0); // 0 -> 1
      step(1, pcv(0), 0, 0, 0, 0);

      // R3: disabled lookup of a held address stays quiet.
      tag = "R3";
      step(0, pcv(0), 0, 0, 0, 0);
      step(1, pcv(9), 0, 0, 0, 0);

      // R8: lookup and resolution on the same address in one cycle.
      tag = "R8";
      step(1, pcv(1), 1, pcv(1), 32'h0, 1);  // lookup sees 3 (not taken)
      step(1, pcv(1), 0, 0, 0, 0);           // now 1 (taken)
      step(1, pcv(5), 1, pcv(5), 32'hC5C5_0000, 1); // insert collision: lookup misses
      step(1, pcv(5), 0, 0, 0, 0);

      // R6: fill remaining empty entries in order.
      tag = "R6";
      for (int k = 2; k < 8; k++) if (k != 5) step(0, 0, 1, pcv(k), 32'h5000_0000 + 32'(k), k[0]);
      for (int k = 0; k < 8; k++) step(1, pcv(k), 0, 0, 0, 0);

      // R7: refresh the oldest via lookup, then evict on insert.
      tag = "R7";
      step(1, pcv(0), 0, 0, 0, 0);
      step(0, 0, 1, pcv(8), 32'h8888_0000, 1);
      for (int k = 0; k < 9; k++) step(1, pcv(k), 0, 0, 0, 0);
      step(1, pcv(2), 1, pcv(9), 32'h9999_0000, 0); // both touches in one cycle
      step(0, 0, 1, pcv(10), 32'hAAAA_0000, 1);
      for (int k = 0; k < 11; k++) step(1, pcv(k), 0, 0, 0, 0);

      // R2 and R7 together: random traffic over twelve addresses.
      tag = "R2";
      for (int c = 0; c < 4000; c++) begin
         step($urandom_range(0, 3) != 0, pcv($urandom_range(0, 11)),
              $urandom_range(0, 1) == 1, pcv($urandom_range(0, 11)),
              $urandom, $urandom_range(0, 2) != 0);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule